// File: doc/BRIEF.md
# Two-Wire Serial EEPROM Slave Controller

This block is the bus-side controller of a 256-byte serial EEPROM on a two-wire (I2C-style) bus. It samples SCL and SDA with the system clock and watches for START and STOP conditions. After a START it shifts in a header byte and compares its upper seven bits with the fixed device identity. The lowest header bit selects read or write. The block acknowledges the header, the byte address and data bytes by pulling SDA low through an open-drain enable. It never drives SDA high.

A single 8-bit address counter serves every transfer. A write transfer loads the counter from the byte address and then stores each data byte at the counter, advancing it by one after each byte. A read sends the byte at the counter and advances it. This gives three read forms. A plain read header continues from the last accessed byte plus one. A write header with only an address, followed by a repeated START and a read header, selects any byte. A master that keeps acknowledging streams further bytes, and the counter rolls from 255 to 0.

The memory itself sits outside the block as a byte array with a combinational read port and a single-cycle write strobe. A busy input from the programming logic makes the controller ignore its own header until the internal write completes. This lets the master poll for completion.

Top module: `eeprom_bus_slave`

## Requirements
- R1: A header byte (sent MSB first) whose upper seven bits equal 1010000 is acknowledged by holding SDA low during the ninth clock. Header bit 0 = 1 selects a read and 0 selects a write.
- R2: A header with any other identity is not acknowledged. The block then releases SDA and writes nothing until the next START.
- R3: While progBusy is high, a matching header is not acknowledged.
- R4: In a write transfer the byte after the header loads the address counter. Each following byte is acknowledged, written at the counter, and the counter then advances by one.
- R5: A write header with one address byte, a repeated START and a read header return the byte at that address.
- R6: A read header after a START with no address returns the byte at the last read or written address plus one.
- R7: In a read, each master acknowledge (SDA low on the ninth clock) makes the block send the next byte. The counter uses all eight bits, so address 255 is followed by address 0.
- R8: A master non-acknowledge ends the read, and SDA stays released until the next START.
- R9: SDA is only pulled low through sdaOe, and sdaOe changes only while SCL is low.
- R10: A START in the middle of a byte abandons that byte, which is not written, and resets the bit count so the next header is received whole.
- R11: After reset sdaOe is 0, memWrEn is 0 and the address counter (memAddr) is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock that samples the bus |
| rstN | input | 1 | Active-low asynchronous reset |
| sclIn | input | 1 | Bus clock line level |
| sdaIn | input | 1 | Bus data line level |
| progBusy | input | 1 | High while the internal write cycle runs |
| sdaOe | output | 1 | 1 pulls SDA low, 0 releases it |
| memAddr | output | 8 | Address counter, used as the memory address |
| memWrEn | output | 1 | Single-cycle write strobe to the memory |
| memWrData | output | 8 | Byte to write |
| memRdData | input | 8 | Byte read combinationally at memAddr |

## Verification
A START from the master can arrive while a data byte is half shifted in. Bit capture and abort then compete for the same bit counter and state register in one cycle. The bench provokes this by sending a repeated START after three bits of a data byte. It judges the outcome by two things: the byte that was cut off must never reach the memory, and the header that follows must be acknowledged with its full eight bits. The wrap of the address counter and the load of a read byte also fall in one cycle. This is judged by a sequential read that crosses address 255 and checks each byte returned.

// File: rtl/ee_slave_pkg.sv
package ee_slave_pkg;
  localparam int DATA_W = 8;

  typedef struct packed {
    logic              start;
    logic              stop;
    logic              rise;
    logic              fall;
    logic              full;
    logic [DATA_W-1:0] rxByte;
    logic              sdaBit;
  } busEv_t;

  typedef struct packed {
    logic clrBit;
    logic ldAddr;
    logic wrByte;
    logic ldTx;
    logic shTx;
    logic ackOn;
    logic relSda;
  } dpCmd_t;
endpackage

// File: rtl/ee_slave_dpath.sv
module ee_slave_dpath
  import ee_slave_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int SYNC_N = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              sclIn,
  input  logic              sdaIn,
  input  dpCmd_t            cmd,
  output busEv_t            ev,
  output logic              sdaOe,
  output logic [ADDR_W-1:0] memAddr,
  output logic              memWrEn,
  output logic [DATA_W-1:0] memWrData,
  input  logic [DATA_W-1:0] memRdData
);
  localparam int CNT_W = $clog2(DATA_W + 1);
  localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(DATA_W);

  logic [SYNC_N-1:0] sclPipe, sdaPipe;
  logic              sclD, sdaD;
  logic              sclS, sdaS;
  logic [CNT_W-1:0]  bitCnt;
  logic [DATA_W-1:0] rxShift, txShift;
  logic [ADDR_W-1:0] addrCnt;

  assign sclS = sclPipe[SYNC_N-1];
  assign sdaS = sdaPipe[SYNC_N-1];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sclPipe <= '1;
      sdaPipe <= '1;
      sclD    <= 1'b1;
      sdaD    <= 1'b1;
    end else begin
      sclPipe <= {sclPipe[SYNC_N-2:0], sclIn};
      sdaPipe <= {sdaPipe[SYNC_N-2:0], sdaIn};
      sclD    <= sclS;
      sdaD    <= sdaS;
    end
  end

  always_comb begin
    ev.start  = sclS & sclD & sdaD & ~sdaS;
    ev.stop   = sclS & sclD & ~sdaD & sdaS;
    ev.rise   = sclS & ~sclD;
    ev.fall   = ~sclS & sclD;
    ev.full   = (bitCnt == FULL_CNT);
    ev.rxByte = rxShift;
    ev.sdaBit = sdaS;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      bitCnt  <= '0;
      rxShift <= '0;
    end else if (cmd.clrBit) begin
      bitCnt  <= '0;
    end else if (ev.rise && !ev.full) begin
      bitCnt  <= bitCnt + 1'b1;
      rxShift <= {rxShift[DATA_W-2:0], sdaS};
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      addrCnt <= '0;
    end else if (cmd.ldAddr) begin
      addrCnt <= rxShift[ADDR_W-1:0];
    end else if (cmd.wrByte || cmd.ldTx) begin
      addrCnt <= addrCnt + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      txShift <= '0;
      sdaOe   <= 1'b0;
    end else if (cmd.ldTx) begin
      txShift <= memRdData;
      sdaOe   <= ~memRdData[DATA_W-1];
    end else if (cmd.shTx) begin
      txShift <= {txShift[DATA_W-2:0], 1'b0};
      sdaOe   <= ~txShift[DATA_W-2];
    end else if (cmd.ackOn) begin
      sdaOe   <= 1'b1;
    end else if (cmd.relSda) begin
      sdaOe   <= 1'b0;
    end
  end

  assign memAddr   = addrCnt;
  assign memWrEn   = cmd.wrByte;
  assign memWrData = rxShift;

  // R9
  sda_scl_low_chk: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(sdaOe) |-> !sclIn);

  // R4
  wr_full_chk: assert property (@(posedge clk) disable iff (!rstN)
    memWrEn |-> (bitCnt == FULL_CNT));

  // R1
  ack_slot_chk: assert property (@(posedge clk) disable iff (!rstN)
    cmd.ackOn |-> (bitCnt == FULL_CNT) && !sclS);

  // R10
  bit_abort_chk: assert property (@(posedge clk) disable iff (!rstN)
    ev.start |=> (bitCnt == '0));
endmodule

// File: rtl/ee_slave_ctrl.sv
module ee_slave_ctrl
  import ee_slave_pkg::*;
#(
  parameter logic [6:0] DEV_ID = 7'b1010000
) (
  input  logic   clk,
  input  logic   rstN,
  input  logic   progBusy,
  input  busEv_t ev,
  output dpCmd_t cmd
);
  typedef enum logic [3:0] {
    S_IDLE, S_HDR, S_HDR_ACK, S_WADR, S_WADR_ACK,
    S_WDAT, S_WDAT_ACK, S_RDAT, S_RACK
  } state_t;

  state_t state, nextState;
  logic   rdMode, rdModeNext;

  always_comb begin
    cmd        = '0;
    nextState  = state;
    rdModeNext = rdMode;
    if (ev.start) begin
      nextState  = S_HDR;
      cmd.clrBit = 1'b1;
      cmd.relSda = 1'b1;
    end else if (ev.stop) begin
      nextState  = S_IDLE;
      cmd.clrBit = 1'b1;
      cmd.relSda = 1'b1;
    end else begin
      case (state)
        S_HDR: if (ev.fall && ev.full) begin
          if (ev.rxByte[7:1] == DEV_ID && !progBusy) begin
            cmd.ackOn  = 1'b1;
            rdModeNext = ev.rxByte[0];
            nextState  = S_HDR_ACK;
          end else begin
            nextState  = S_IDLE;
          end
        end
        S_HDR_ACK: if (ev.fall) begin
          cmd.clrBit = 1'b1;
          if (rdMode) begin
            cmd.ldTx  = 1'b1;
            nextState = S_RDAT;
          end else begin
            cmd.relSda = 1'b1;
            nextState  = S_WADR;
          end
        end
        S_WADR: if (ev.fall && ev.full) begin
          cmd.ldAddr = 1'b1;
          cmd.ackOn  = 1'b1;
          nextState  = S_WADR_ACK;
        end
        S_WADR_ACK, S_WDAT_ACK: if (ev.fall) begin
          cmd.clrBit = 1'b1;
          cmd.relSda = 1'b1;
          nextState  = S_WDAT;
        end
        S_WDAT: if (ev.fall && ev.full) begin
          cmd.wrByte = 1'b1;
          cmd.ackOn  = 1'b1;
          nextState  = S_WDAT_ACK;
        end
        S_RDAT: if (ev.fall) begin
          if (ev.full) begin
            cmd.relSda = 1'b1;
            nextState  = S_RACK;
          end else begin
            cmd.shTx = 1'b1;
          end
        end
        S_RACK: begin
          if (ev.rise && ev.sdaBit) begin
            nextState = S_IDLE;
          end else if (ev.fall) begin
            cmd.clrBit = 1'b1;
            cmd.ldTx   = 1'b1;
            nextState  = S_RDAT;
          end
        end
        default: nextState = state;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state  <= S_IDLE;
      rdMode <= 1'b0;
    end else begin
      state  <= nextState;
      rdMode <= rdModeNext;
    end
  end

  // R3
  busy_nak_chk: assert property (@(posedge clk) disable iff (!rstN)
    (state == S_HDR && ev.fall && ev.full && progBusy) |=> (state == S_IDLE));
endmodule

// File: rtl/eeprom_bus_slave.sv
module eeprom_bus_slave
  import ee_slave_pkg::*;
#(
  parameter int         ADDR_W = 8,
  parameter int         SYNC_N = 2,
  parameter logic [6:0] DEV_ID = 7'b1010000
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              sclIn,
  input  logic              sdaIn,
  input  logic              progBusy,
  output logic              sdaOe,
  output logic [ADDR_W-1:0] memAddr,
  output logic              memWrEn,
  output logic [DATA_W-1:0] memWrData,
  input  logic [DATA_W-1:0] memRdData
);
  busEv_t busEv;
  dpCmd_t dpCmd;

  ee_slave_ctrl #(.DEV_ID(DEV_ID)) u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .progBusy (progBusy),
    .ev       (busEv),
    .cmd      (dpCmd)
  );

  ee_slave_dpath #(.ADDR_W(ADDR_W), .SYNC_N(SYNC_N)) u_dpath (
    .clk       (clk),
    .rstN      (rstN),
    .sclIn     (sclIn),
    .sdaIn     (sdaIn),
    .cmd       (dpCmd),
    .ev        (busEv),
    .sdaOe     (sdaOe),
    .memAddr   (memAddr),
    .memWrEn   (memWrEn),
    .memWrData (memWrData),
    .memRdData (memRdData)
  );
endmodule

// File: tb/sim_eeprom_bus_slave.sv
`timescale 1ns/1ps
module sim_eeprom_bus_slave;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic sclM = 1'b1;
  logic mSda = 1'b1;
  logic progBusy = 1'b0;
  logic sdaOe, memWrEn;
  logic [7:0] memAddr, memWrData, memRdData;
  logic sdaLine;
  logic [7:0] mem [256];
  int nChk = 0, nFail = 0, wrCount = 0, sclViol = 0;
  logic sdaOePrev = 1'b0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  assign sdaLine   = mSda & ~sdaOe;
  assign memRdData = mem[memAddr];

  eeprom_bus_slave u0 (
    .clk(clk), .rstN(rstN), .sclIn(sclM), .sdaIn(sdaLine),
    .progBusy(progBusy), .sdaOe(sdaOe), .memAddr(memAddr),
    .memWrEn(memWrEn), .memWrData(memWrData), .memRdData(memRdData)
  );

  initial for (int i = 0; i < 256; i++) mem[i] = 8'(i) ^ 8'h5A;

  always @(posedge clk) begin
    if (memWrEn) begin
      mem[memAddr] <= memWrData;
      wrCount++;
    end
    if (rstN && (sdaOe !== sdaOePrev) && sclM) sclViol++;
    sdaOePrev <= sdaOe;
  end

  task automatic waitN(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    nChk++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic busStart();
    mSda = 1'b1; waitN(4); sclM = 1'b1; waitN(6);
    mSda = 1'b0; waitN(6); sclM = 1'b0; waitN(4);
  endtask

  task automatic busStop();
    mSda = 1'b0; waitN(4); sclM = 1'b1; waitN(6); mSda = 1'b1; waitN(6);
  endtask

  task automatic sendBit(input logic b);
    mSda = b; waitN(4); sclM = 1'b1; waitN(8); sclM = 1'b0; waitN(4);
  endtask

  task automatic getBit(output logic b);
    mSda = 1'b1; waitN(4); sclM = 1'b1; waitN(4); b = sdaLine;
    waitN(4); sclM = 1'b0; waitN(4);
  endtask

  task automatic sendByte(input logic [7:0] v, output logic ack);
    logic a;
    for (int i = 7; i >= 0; i--) sendBit(v[i]);
    getBit(a);
    ack = ~a;
  endtask

  task automatic recvByte(output logic [7:0] v, input logic mAck);
    logic b;
    for (int i = 7; i >= 0; i--) begin getBit(b); v[i] = b; end
    sendBit(~mAck);
  endtask

  task automatic writeAt(input logic [7:0] a, input logic [7:0] d, output logic ok);
    logic k1, k2, k3;
    busStart(); sendByte(8'hA0, k1); sendByte(a, k2); sendByte(d, k3); busStop();
    ok = k1 & k2 & k3;
  endtask

  task automatic randRead(input logic [7:0] a, output logic [7:0] d, output logic ok);
    logic k1, k2, k3;
    busStart(); sendByte(8'hA0, k1); sendByte(a, k2);
    busStart(); sendByte(8'hA1, k3); recvByte(d, 1'b0); busStop();
    ok = k1 & k2 & k3;
  endtask

  task automatic curRead(output logic [7:0] d, output logic ok);
    busStart(); sendByte(8'hA1, ok); recvByte(d, 1'b0); busStop();
  endtask

  task automatic finishRun();
    $display("== %0d vectors applied, %0d miscompares ==", nChk, nFail);
    $finish;
  endtask

  // kind: 0 = write addr/data, 1 = random read addr expect data, 2 = current-address read expect data
  localparam logic [17:0] VEC [10] = '{
    {2'd0, 8'h10, 8'hA5},
    {2'd0, 8'h11, 8'h5A},
    {2'd1, 8'h10, 8'hA5},
    {2'd2, 8'h00, 8'h5A},
    {2'd0, 8'hFF, 8'hC3},
    {2'd0, 8'h00, 8'h3C},
    {2'd1, 8'hFF, 8'hC3},
    {2'd2, 8'h00, 8'h3C},
    {2'd2, 8'h00, 8'h5B},
    {2'd1, 8'h11, 8'h5A}
  };

  initial begin
    logic ok, k;
    logic [7:0] d;
    int wrBefore;
    waitN(5);
    // R11 reset state
    chk("R11 sdaOe", sdaOe, 0);
    chk("R11 memWrEn", memWrEn, 0);
    chk("R11 memAddr", memAddr, 0);
    rstN = 1'b1;
    waitN(5);

    for (int v = 0; v < 10; v++) begin
      case (VEC[v][17:16])
        2'd0: begin writeAt(VEC[v][15:8], VEC[v][7:0], ok); chk("R1 R4 write acks", ok, 1); end
        2'd1: begin randRead(VEC[v][15:8], d, ok); chk("R5 random read acks", ok, 1); chk("R5 random read data", d, VEC[v][7:0]); end
        default: begin curRead(d, ok); chk("R6 R7 current read ack", ok, 1); chk("R6 R7 current read data", d, VEC[v][7:0]); end
      endcase
    end

    // R2 foreign identity: no ack, no write
    wrBefore = wrCount;
    busStart(); sendByte(8'hA2, k); chk("R2 header nack", k, 0);
    sendByte(8'h20, k); chk("R2 address ignored", k, 0);
    sendByte(8'h77, k); chk("R2 data ignored", k, 0);
    busStop();
    chk("R2 no write", wrCount - wrBefore, 0);
    randRead(8'h20, d, ok); chk("R2 byte intact", d, 8'h7A);

    // R3 busy suppresses header ack
    progBusy = 1'b1;
    busStart(); sendByte(8'hA0, k); busStop();
    chk("R3 busy nack", k, 0);
    progBusy = 1'b0;
    busStart(); sendByte(8'hA0, k); busStop();
    chk("R3 idle ack", k, 1);

    // R7 sequential read across the top of the array, R8 nack end
    busStart(); sendByte(8'hA0, k); sendByte(8'hFE, ok); ok = ok & k;
    busStart(); sendByte(8'hA1, k); ok = ok & k;
    chk("R7 seq acks", ok, 1);
    recvByte(d, 1'b1); chk("R7 seq FE", d, 8'hA4);
    recvByte(d, 1'b1); chk("R7 seq FF", d, 8'hC3);
    recvByte(d, 1'b1); chk("R7 seq wrap 00", d, 8'h3C);
    recvByte(d, 1'b0); chk("R7 seq 01", d, 8'h5B);
    d = 8'hFF;
    for (int i = 0; i < 9; i++) begin getBit(k); d = d & {7'h7F, k}; end
    chk("R8 released after nack", d[0], 1);
    busStop();

    // R10 START mid-byte aborts
    wrBefore = wrCount;
    busStart(); sendByte(8'hA0, k); sendByte(8'h40, ok);
    sendBit(1'b1); sendBit(1'b0); sendBit(1'b1);
    busStart(); sendByte(8'hA0, k); chk("R10 header after abort", k, 1);
    sendByte(8'h41, k); sendByte(8'h99, k); busStop();
    chk("R10 one write only", wrCount - wrBefore, 1);
    randRead(8'h40, d, ok); chk("R10 aborted byte not written", d, 8'h1A);
    randRead(8'h41, d, ok); chk("R4 new byte written", d, 8'h99);

    // R6 current read after a write
    writeAt(8'h60, 8'h77, ok);
    curRead(d, ok); chk("R6 after write", d, 8'h3B);

    // R9 sdaOe only toggles with SCL low
    chk("R9 sda change with scl high", sclViol, 0);

    done = 1'b1;
    finishRun();
  end

  initial begin
    waitN(190000);
    if (!done) begin
      nFail++;
      $display("FAIL watchdog actual=hung expected=done");
      finishRun();
    end
  end
endmodule